// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Controller

This block controls operand forwarding for a single-issue, six-stage, in-order pipeline. The stages are fetch-address, fetch, decode/register-read, ALU, memory and writeback. Each cycle it receives the two source register numbers of the instruction in decode. It also receives that instruction's destination number, a write flag and a load flag. Because source fields sit at fixed bit positions, the lookup can run alongside the rest of decode.

The block keeps its own short record of the two older instructions still in flight: the one now in the ALU stage and the one now in the memory stage. It compares each of their destinations with each source, which gives four comparisons. For each operand it produces a mux select for the ALU input: register bank, ALU-stage result or memory-stage result.

A load whose result is needed by the very next instruction cannot be bypassed. For that case the block raises a one-cycle stall and pushes a non-writing bubble into its record. Decode holds the stalled instruction, and on the next cycle it picks up the loaded value from the memory-stage path. A flush input marks the decode instruction as squashed after a taken branch, so it is never recorded as a producer.

Top module: `fwd_ctrl`

## Requirements
- R1: The select encoding is 0 for the register bank, 1 for the ALU-stage result and 2 for the memory-stage result. The value 3 never appears, and a source with no matching producer selects 0.
- R2: A source equal to the destination of the instruction issued one cycle earlier, with its write flag set, selects 1.
- R3: A source equal to the destination of the instruction issued two cycles earlier, with its write flag set, selects 2, unless R4 applies.
- R4: When both recorded producers write the register a source names, the younger one wins and the select is 1.
- R5: With ZERO_REG = 1, source register 0 always selects 0 and never causes a stall, even if a producer names register 0.
- R6: A producer with its write flag clear, such as a compare or a store, never causes forwarding or a stall.
- R7: When a valid, unflushed instruction reads on either operand the destination of a load issued one cycle earlier, stall is high for exactly one cycle. During that cycle the matching operand's select is 1.
- R8: The cycle after a stall, the held instruction sees no ALU-stage producer, and the load appears as the memory-stage producer (select 2, stall low).
- R9: An instruction presented with flush high, or with valid low, is not recorded as a producer. No stall is raised while flush is high.
- R10: While reset is asserted, and on the first cycle after it, both selects are 0 and stall is low, whatever the inputs are.
- R11: The two operands are resolved independently, so they may select different paths in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| id_valid | input | 1 | Decode holds a real instruction |
| id_flush | input | 1 | Decode instruction is squashed by a taken branch |
| id_src_a | input | AW | First source register number |
| id_src_b | input | AW | Second source register number |
| id_dst | input | AW | Destination register number of the decode instruction |
| id_wr | input | 1 | Decode instruction writes its destination |
| id_load | input | 1 | Decode instruction is a load |
| sel_a | output | 2 | Operand A bypass select (0 bank, 1 ALU stage, 2 memory stage) |
| sel_b | output | 2 | Operand B bypass select (0 bank, 1 ALU stage, 2 memory stage) |
| stall | output | 1 | Hold decode for one cycle on a load-use hazard |

## Verification
The stimulus goes after producer priority when both older instructions write the same register. A design that reversed the priority would feed the operand stale memory-stage data. It also covers register 0 named as a destination, where a wrong design forwards a value that should read as zero. Other cases are compares that write nothing, and the cycle after a load-use stall. There, a missing bubble shows up as a repeated stall or as a select of the ALU stage. Further checks confirm that flushed or invalid slots never appear as producers and that operand B can trigger the stall as well as operand A. Otherwise a squashed instruction would hand a later one a wrong value, or a hazard would go undetected.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_ALU = 2'd1,
    FWD_MEM = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/fwd_track.sv
// Record of the two in-flight producers: slot 0 = ALU stage, slot 1 = memory stage.
module fwd_track #(
  parameter int AW    = 5,
  parameter int DEPTH = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             push_dst,
  input  logic                      push_wr,
  input  logic                      push_ld,
  output logic [DEPTH-1:0][AW-1:0]  dst_o,
  output logic [DEPTH-1:0]          wr_o,
  output logic                      alu_ld_o
);
  typedef struct packed {
    logic [AW-1:0] dst;
    logic          wr;
    logic          ld;
  } rec_t;

  rec_t rec_q [DEPTH];
  rec_t rec_d [DEPTH];
  logic adv_en;

  assign adv_en = 1'b1;  // the record shifts every cycle; a stall pushes a bubble

  always_comb begin
    rec_d[0].dst = push_dst;
    rec_d[0].wr  = push_wr;
    rec_d[0].ld  = push_ld & push_wr;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_shift
    always_comb rec_d[s] = rec_q[s-1];
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rec_q[s] <= '0;
      end else if (adv_en) begin
        rec_q[s] <= rec_d[s];
      end
    end
    assign dst_o[s] = rec_q[s].dst;
    assign wr_o[s]  = rec_q[s].wr;
  end

  assign alu_ld_o = rec_q[0].ld;
endmodule

// File: rtl/fwd_match.sv
// Per-operand comparison against both producers with youngest-first priority.
module fwd_match
  import fwd_pkg::*;
#(
  parameter int AW       = 5,
  parameter bit ZERO_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      src_i,
  input  logic [1:0][AW-1:0] dst_i,
  input  logic [1:0]         wr_i,
  output fwd_sel_e           sel_o,
  output logic [1:0]         hit_o
);
  logic src_live;

  assign src_live = !(ZERO_REG && (src_i == '0));

  for (genvar p = 0; p < 2; p++) begin : g_cmp
    assign hit_o[p] = src_live & wr_i[p] & (dst_i[p] == src_i);
  end

  always_comb begin
    if (hit_o[0])      sel_o = FWD_ALU;
    else if (hit_o[1]) sel_o = FWD_MEM;
    else               sel_o = FWD_RF;
  end

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o != fwd_sel_e'(2'd3));  // R1

  AST_ZERO_NEVER_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (ZERO_REG && src_i == '0) |-> (sel_o == FWD_RF && hit_o == 2'b00));  // R5
endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int AW       = 5,
  parameter bit ZERO_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_valid,
  input  logic          id_flush,
  input  logic [AW-1:0] id_src_a,
  input  logic [AW-1:0] id_src_b,
  input  logic [AW-1:0] id_dst,
  input  logic          id_wr,
  input  logic          id_load,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          stall
);
  localparam int DEPTH = 2;
  localparam int NSRC  = 2;

  logic [DEPTH-1:0][AW-1:0] prod_dst;
  logic [DEPTH-1:0]         prod_wr;
  logic                     alu_is_load;
  logic [NSRC-1:0][AW-1:0]  src;
  logic [NSRC-1:0][1:0]     hit;
  fwd_sel_e                 sel [NSRC];
  logic                     issue;
  logic                     load_use;

  assign src[0] = id_src_a;
  assign src[1] = id_src_b;

  for (genvar k = 0; k < NSRC; k++) begin : g_op
    fwd_match #(.AW(AW), .ZERO_REG(ZERO_REG)) u_match (
      .clk   (clk),
      .rst_n (rst_n),
      .src_i (src[k]),
      .dst_i (prod_dst),
      .wr_i  (prod_wr),
      .sel_o (sel[k]),
      .hit_o (hit[k])
    );
  end

  assign load_use = alu_is_load & (hit[0][0] | hit[1][0]);
  assign stall    = id_valid & ~id_flush & load_use;
  assign issue    = id_valid & ~id_flush & ~stall;

  fwd_track #(.AW(AW), .DEPTH(DEPTH)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_dst (id_dst),
    .push_wr  (issue & id_wr),
    .push_ld  (issue & id_load),
    .dst_o    (prod_dst),
    .wr_o     (prod_wr),
    .alu_ld_o (alu_is_load)
  );

  assign sel_a = sel[0];
  assign sel_b = sel[1];

  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);  // R7

  AST_BUBBLE_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (sel_a != 2'd1 && sel_b != 2'd1));  // R8

  AST_FLUSH_NOT_PRODUCER: assert property (@(posedge clk) disable iff (!rst_n)
    id_flush |=> (sel_a != 2'd1 && sel_b != 2'd1));  // R9

  AST_NO_STALL_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    id_flush |-> !stall);  // R9
endmodule

// File: tb/tb_fwd_ctrl.sv
module tb_fwd_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       id_valid, id_flush, id_wr, id_load;
  logic [4:0] id_src_a, id_src_b, id_dst;
  logic [1:0] sel_a, sel_b;
  logic       stall;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fwd_ctrl #(.AW(5), .ZERO_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_flush(id_flush),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_dst(id_dst),
    .id_wr(id_wr), .id_load(id_load),
    .sel_a(sel_a), .sel_b(sel_b), .stall(stall)
  );

  typedef struct packed {
    logic       v;
    logic       fl;
    logic [4:0] sa;
    logic [4:0] sb;
    logic [4:0] d;
    logic       wr;
    logic       ld;
    logic [1:0] ea;
    logic [1:0] eb;
    logic       es;
  } vec_t;

  localparam int NV = 18;
  // fields: v fl sa sb d wr ld | expected sel_a sel_b stall
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,5'd2, 5'd3, 5'd1, 1'b1,1'b0, 2'd0,2'd0,1'b0}, // 0  R1 empty record
    '{1'b1,1'b0,5'd1, 5'd5, 5'd4, 1'b1,1'b0, 2'd1,2'd0,1'b0}, // 1  R2
    '{1'b1,1'b0,5'd1, 5'd4, 5'd6, 1'b1,1'b0, 2'd2,2'd1,1'b0}, // 2  R3 R11
    '{1'b1,1'b0,5'd6, 5'd4, 5'd9, 1'b0,1'b0, 2'd1,2'd2,1'b0}, // 3  compare, no write
    '{1'b1,1'b0,5'd9, 5'd6, 5'd7, 1'b1,1'b0, 2'd0,2'd2,1'b0}, // 4  R6 ALU slot
    '{1'b1,1'b0,5'd9, 5'd7, 5'd7, 1'b1,1'b0, 2'd0,2'd1,1'b0}, // 5  R6 mem slot
    '{1'b1,1'b0,5'd7, 5'd0, 5'd0, 1'b1,1'b0, 2'd1,2'd0,1'b0}, // 6  R4 both write 7
    '{1'b1,1'b0,5'd0, 5'd0, 5'd3, 1'b1,1'b1, 2'd0,2'd0,1'b0}, // 7  R5 r0 producer
    '{1'b1,1'b0,5'd3, 5'd0, 5'd8, 1'b1,1'b0, 2'd1,2'd0,1'b1}, // 8  R7 load-use on A
    '{1'b1,1'b0,5'd3, 5'd0, 5'd8, 1'b1,1'b0, 2'd2,2'd0,1'b0}, // 9  R8 held instruction
    '{1'b1,1'b0,5'd8, 5'd8, 5'd5, 1'b1,1'b1, 2'd1,2'd1,1'b0}, // 10 load of r5
    '{1'b1,1'b1,5'd2, 5'd5, 5'd2, 1'b1,1'b0, 2'd0,2'd1,1'b0}, // 11 R9 flush, no stall
    '{1'b1,1'b0,5'd2, 5'd5, 5'd1, 1'b1,1'b0, 2'd0,2'd2,1'b0}, // 12 R9 flushed not recorded
    '{1'b0,1'b0,5'd1, 5'd1, 5'd9, 1'b1,1'b0, 2'd1,2'd1,1'b0}, // 13 invalid slot
    '{1'b1,1'b0,5'd1, 5'd2, 5'd11,1'b1,1'b0, 2'd2,2'd0,1'b0}, // 14 R9 invalid not recorded
    '{1'b1,1'b0,5'd0, 5'd0, 5'd10,1'b1,1'b1, 2'd0,2'd0,1'b0}, // 15 load of r10
    '{1'b1,1'b0,5'd11,5'd10,5'd12,1'b1,1'b0, 2'd2,2'd1,1'b1}, // 16 R7 load-use on B
    '{1'b1,1'b0,5'd11,5'd10,5'd12,1'b1,1'b0, 2'd0,2'd2,1'b0}  // 17 R8 after stall
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t t);
    id_valid = t.v;  id_flush = t.fl;
    id_src_a = t.sa; id_src_b = t.sb; id_dst = t.d;
    id_wr    = t.wr; id_load  = t.ld;
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive('{1'b1,1'b0,5'd4,5'd4,5'd4,1'b1,1'b1,2'd0,2'd0,1'b0});
    @(negedge clk); #1;
    check("R10 reset sel_a", sel_a, 2'd0);
    check("R10 reset stall", {1'b0, stall}, 2'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #1;
      check($sformatf("vec%0d sel_a", i), sel_a, VECS[i].ea);
      check($sformatf("vec%0d sel_b", i), sel_b, VECS[i].eb);
      check($sformatf("vec%0d stall", i), {1'b0, stall}, {1'b0, VECS[i].es});
    end

    // R10: a load in flight is forgotten by reset
    @(negedge clk);
    drive('{1'b1,1'b0,5'd0,5'd0,5'd4,1'b1,1'b1,2'd0,2'd0,1'b0});
    @(negedge clk);
    drive('{1'b1,1'b0,5'd4,5'd4,5'd6,1'b1,1'b0,2'd0,2'd0,1'b0});
    #1;
    check("R7 load-use before reset", {1'b0, stall}, 2'd1);
    rst_n = 1'b0;
    #1;
    check("R10 sel_a in reset", sel_a, 2'd0);
    check("R10 stall in reset", {1'b0, stall}, 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 sel_b after reset", sel_b, 2'd0);
    check("R10 stall after reset", {1'b0, stall}, 2'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule